// File: doc/BRIEF.md
# Supervisor-Gated Special Register Bank

This block holds the three privileged control registers of a small processor core: the status word, the saved program counter captured at exception entry, and the saved status word captured at the same time. The core reaches them through move-to and move-from requests that carry a register index. Only a core running in supervisor mode may see or change them. A request made in user mode is refused and reported on a violation output, so that the core can raise a fault.

The block also carries out the return-from-exception step. On that strobe it offers the saved program counter as the next fetch address, and it reloads the status word from its saved copy. Because the supervisor bit lives in the status word, one return can drop the core from supervisor to user mode, or lift it back up.

Reads are combinational from the current register contents. Writes and the status restore take effect at the next rising clock edge.

Top module: `sup_spr_bank`

## Requirements
- R1: After reset the status word (index 0) reads 0x00000001, which means the supervisor bit (bit 0) is set. The saved PC (index 1) and the saved status (index 2) read 0.
- R2: When the supervisor bit is set, a write strobe to index 0, 1 or 2 loads `wr_data` into that register at the next rising edge.
- R3: When the supervisor bit is clear, a write strobe changes no register.
- R4: When the supervisor bit is set, a read strobe returns the register's contents from before the current edge. When the bit is clear, a read returns 0. With no read strobe, `rd_data` is 0.
- R5: `priv_viol` is high in exactly the cycles in which a read or write strobe is present while the supervisor bit is clear. It is never high in any other cycle.
- R6: `next_pc` always shows the saved PC register, and this is the address a return-from-exception uses.
- R7: A `rfe` strobe loads the status word with the saved status at the next edge. This happens whatever the supervisor bit is.
- R8: If `rfe` and a supervisor write to index 0 occur in the same cycle, the status word takes the saved status and the written data is lost.
- R9: In supervisor mode, indices other than 0, 1 and 2 read as 0 and raise no violation, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx | input | 4 | Register index of the access |
| wr_en | input | 1 | Move-to-register strobe |
| wr_data | input | 32 | Data to write |
| rd_en | input | 1 | Move-from-register strobe |
| rd_data | output | 32 | Read result, 0 when refused or idle |
| rfe | input | 1 | Return-from-exception strobe |
| next_pc | output | 32 | Resume address taken from the saved PC |
| priv_viol | output | 1 | Pulse marking a refused user-mode access |

## Verification
The embedded assertions run on every cycle. They check that refused writes leave all three registers unchanged and that refused reads return zero. They also check that a supervisor write to the saved PC arrives one edge later, that every return loads the status from its saved copy (even when a status write competes), and that unimplemented indices read zero without a violation. The reset values, the exact cycle in which a violation pulse appears, and the read-before-write result of a combined access can only be shown by the bench scenarios. The same holds for round trips in which a return drops the core into user mode or raises it back to supervisor.

// File: rtl/sup_spr_bank.sv
module sup_spr_bank #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int STAT_IDX = 0,
  parameter int EPC_IDX  = 1,
  parameter int ESR_IDX  = 2,
  parameter int SUP_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rfe,
  output logic [DATA_W-1:0] next_pc,
  output logic              priv_viol
);

  localparam logic [IDX_W-1:0]  A_STAT   = IDX_W'(STAT_IDX);
  localparam logic [IDX_W-1:0]  A_EPC    = IDX_W'(EPC_IDX);
  localparam logic [IDX_W-1:0]  A_ESR    = IDX_W'(ESR_IDX);
  localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(1) << SUP_BIT;

  logic [DATA_W-1:0] stat_q, epc_q, esr_q;

  wire sup      = stat_q[SUP_BIT];
  wire hit_stat = (idx == A_STAT);
  wire hit_epc  = (idx == A_EPC);
  wire hit_esr  = (idx == A_ESR);
  wire wr_ok    = wr_en & sup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      epc_q  <= '0;
      esr_q  <= '0;
    end else begin
      if (rfe)
        stat_q <= esr_q;
      else if (wr_ok && hit_stat)
        stat_q <= wr_data;
      if (wr_ok && hit_epc) epc_q <= wr_data;
      if (wr_ok && hit_esr) esr_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && sup) begin
      if (hit_stat)     rd_data = stat_q;
      else if (hit_epc) rd_data = epc_q;
      else if (hit_esr) rd_data = esr_q;
    end
  end

  assign next_pc   = epc_q;
  assign priv_viol = (wr_en | rd_en) & ~sup;

  // Refused write leaves every register untouched
  assert_user_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup && !rfe) |=> (stat_q == $past(stat_q) && epc_q == $past(epc_q) && esr_q == $past(esr_q)));

  assert_user_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sup) |-> (rd_data == '0 && priv_viol));

  assert_viol_only_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> (rd_data == '0 && (rd_en || wr_en)));

  assert_sup_write_epc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sup && hit_epc) |=> (next_pc == $past(wr_data)));

  assert_rfe_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rfe |=> (stat_q == $past(esr_q)));

  assert_rfe_beats_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && wr_en && sup && hit_stat) |=> (stat_q == $past(esr_q)));

  assert_unimpl_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sup && !hit_stat && !hit_epc && !hit_esr) |-> (rd_data == '0 && !priv_viol));

endmodule

// File: tb/sup_spr_bank_tb.sv
module sup_spr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rfe = 1'b0;
  logic [31:0] next_pc;
  logic        priv_viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sup_spr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rfe(rfe), .next_pc(next_pc), .priv_viol(priv_viol)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        rt;
    logic [3:0]  ix;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_v;
    logic [31:0] exp_pc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,4'd0,32'h0,        32'h1,    1'b0,32'h0},    // R1 status
    '{1'b0,1'b1,1'b0,4'd1,32'h0,        32'h0,    1'b0,32'h0},    // R1 saved pc
    '{1'b1,1'b0,1'b0,4'd1,32'h1000,     32'h0,    1'b0,32'h0},    // R2 write pc
    '{1'b0,1'b1,1'b0,4'd1,32'h0,        32'h1000, 1'b0,32'h1000}, // R2 R6
    '{1'b1,1'b0,1'b0,4'd2,32'h6,        32'h0,    1'b0,32'h1000}, // R2 write esr
    '{1'b0,1'b1,1'b0,4'd2,32'h0,        32'h6,    1'b0,32'h1000}, // R2 R4
    '{1'b0,1'b1,1'b0,4'd5,32'h0,        32'h0,    1'b0,32'h1000}, // R9 read
    '{1'b1,1'b0,1'b0,4'd5,32'hFFFFFFFF, 32'h0,    1'b0,32'h1000}, // R9 write
    '{1'b0,1'b1,1'b0,4'd5,32'h0,        32'h0,    1'b0,32'h1000}, // R9 still 0
    '{1'b1,1'b0,1'b0,4'd0,32'h3,        32'h0,    1'b0,32'h1000}, // R2 status
    '{1'b0,1'b1,1'b0,4'd0,32'h0,        32'h3,    1'b0,32'h1000}, // R2 R4
    '{1'b1,1'b0,1'b1,4'd0,32'h1,        32'h0,    1'b0,32'h1000}, // R8 R6
    '{1'b0,1'b1,1'b0,4'd0,32'h0,        32'h0,    1'b1,32'h1000}, // R8 R4 R5 user now
    '{1'b1,1'b0,1'b0,4'd1,32'hDEAD,     32'h0,    1'b1,32'h1000}, // R3 R5
    '{1'b0,1'b0,1'b1,4'd0,32'h0,        32'h0,    1'b0,32'h1000}, // R3 pc kept
    '{1'b0,1'b0,1'b0,4'd0,32'h0,        32'h0,    1'b0,32'h1000}  // R5 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic t,
                       input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; rfe = t; idx = i; wr_data = d;
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].wr, VEC[k].rd, VEC[k].rt, VEC[k].ix, VEC[k].wd);
      chk($sformatf("vec%0d rd_data R4", k), rd_data, VEC[k].exp_rd);
      chk($sformatf("vec%0d priv_viol R5", k), {31'b0, priv_viol}, {31'b0, VEC[k].exp_v});
      chk($sformatf("vec%0d next_pc R6", k), next_pc, VEC[k].exp_pc);
    end

    // Reset state again, from user mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    chk("R1 status after reset", rd_data, 32'h1);
    chk("R1 next_pc after reset", next_pc, 32'h0);
    drive(1'b0, 1'b1, 1'b0, 4'd2, 32'h0);
    chk("R1 saved status after reset", rd_data, 32'h0);

    // Set up saved state, then leave supervisor mode by a write
    drive(1'b1, 1'b0, 1'b0, 4'd2, 32'h11);
    drive(1'b1, 1'b0, 1'b0, 4'd1, 32'h2000);
    drive(1'b1, 1'b0, 1'b0, 4'd0, 32'h10);
    drive(1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    chk("R4 user read status", rd_data, 32'h0);
    chk("R5 user read pulse", {31'b0, priv_viol}, 32'h1);
    drive(1'b0, 1'b1, 1'b0, 4'd7, 32'h0);
    chk("R5 user read unimplemented pulse", {31'b0, priv_viol}, 32'h1);

    // Return lifts back to supervisor
    drive(1'b0, 1'b0, 1'b1, 4'd0, 32'h0);
    chk("R6 next_pc on rfe", next_pc, 32'h2000);
    drive(1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    chk("R7 status restored", rd_data, 32'h11);
    chk("R7 no violation after restore", {31'b0, priv_viol}, 32'h0);

    // Read and write in the same cycle
    drive(1'b1, 1'b1, 1'b0, 4'd1, 32'h3000);
    chk("R4 read before write", rd_data, 32'h2000);
    drive(1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
    chk("R2 write landed", next_pc, 32'h3000);
    chk("R5 idle no pulse", {31'b0, priv_viol}, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule